// File: doc/BRIEF.md
# Linked Descriptor Fetch Sequencer

This block walks a chain of transfer descriptors held in memory and hands each one to a transfer engine. Software first loads the address of the first descriptor and then sets a start level. The sequencer issues a read request on a bus-master port and waits for the grant. It then collects five 32-bit words, each taken from the top lane of a 128-bit read bus. The done beat arrives with the fifth word, and at that point the sequencer presents the decoded descriptor on a valid/ready output.

Each descriptor has five words. Word 0 is a control word. Word 1 holds the link to the next descriptor and a terminator flag. Words 2 and 3 are the destination and source addresses. Word 4 is a spare word that the block reads but ignores. After the engine accepts a descriptor, the sequencer fetches the next one from the link address. When the accepted descriptor carries the terminator flag, the sequencer stops and stays stopped until the start level is cleared. The sequencer fetches only one descriptor at a time. It does not fetch the next one until the engine has taken the current one.

States: `ST_IDLE` (waiting for start), `ST_REQUEST` (request raised, waiting for grant), `ST_RECEIVE` (capturing beats), `ST_PRESENT` (descriptor offered downstream) and `ST_FINISHED` (chain complete). Transitions:
- IDLE→REQUEST when start is high; the first pointer is loaded here.
- REQUEST→RECEIVE on grant.
- RECEIVE→PRESENT on a valid beat that carries done.
- PRESENT→REQUEST when the engine accepts a descriptor that is not the last; the link pointer is loaded here.
- PRESENT→FINISHED when the engine accepts the last descriptor.
- Any state→IDLE when start is low or reset is high.

Top module: `desc_chain_fetcher`

## Requirements
- R1: While reset is high, and afterwards while start is low, `rd_req` and `dsc_valid` are both 0.
- R2: After start rises in the idle state, `rd_req` is 1 on the next cycle and `rd_addr` equals `first_ptr`.
- R3: `rd_req` stays high with a stable `rd_addr` until `rd_grant` is seen. It is low on the cycle after the grant.
- R4: Beats are captured from `rd_data[127:96]`, and only when `rd_valid` is high during the receive phase. Valid or done beats at any other time change nothing. The beat that carries done is the fifth word, and the descriptor is offered on the cycle after it.
- R5: Control word decode: size is bits 31:13, the repeat count is bits 12:7, the destination-fixed flag is bit 6, the source-fixed flag is bit 5, and the direction is bit 1 (1 = write). Bits 4:2 and 0 are ignored.
- R6: Word 2 is the destination address and word 3 is the source address. Word 4 has no effect.
- R7: In word 1, bit 0 is the terminator flag. The next descriptor address is word 1 with bits 1:0 cleared.
- R8: While `dsc_valid` is high and `dsc_ready` is low, the offered descriptor stays unchanged and no read request is raised.
- R9: On the cycle after a non-terminating descriptor is accepted, `rd_req` is 1 with `rd_addr` equal to that descriptor's next address.
- R10: After a terminating descriptor is accepted, no further request is raised while start stays high. Clearing start and setting it again restarts the walk from `first_ptr`.
- R11: Clearing start in any state returns the block to idle on the next cycle, drops `rd_req` and `dsc_valid`, and discards a partly loaded descriptor. The next start loads from word 0 again.
- R12: A synchronous reset in the middle of a fetch behaves like R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_en | input | 1 | Start level from the register file |
| first_ptr | input | 32 | Address of the first descriptor |
| rd_req | output | 1 | Read request to the bus master |
| rd_addr | output | 32 | Address of the descriptor being fetched |
| rd_grant | input | 1 | Request accepted by the bus master |
| rd_valid | input | 1 | A read beat is present |
| rd_done | input | 1 | Marks the final beat of the descriptor |
| rd_data | input | 128 | Read data; the word is in bits 127:96 |
| dsc_valid | output | 1 | A decoded descriptor is offered |
| dsc_ready | input | 1 | The engine takes the offered descriptor |
| dsc_size | output | 19 | Transfer size field |
| dsc_repeat | output | 6 | Repeat count field |
| dsc_wr_fix | output | 1 | Destination address held fixed |
| dsc_rd_fix | output | 1 | Source address held fixed |
| dsc_is_write | output | 1 | Direction, 1 = write |
| dsc_wr_addr | output | 32 | Destination address |
| dsc_rd_addr | output | 32 | Source address |
| dsc_last | output | 1 | Terminator flag of the offered descriptor |

## Verification
The assertions make several assumptions about the inputs:
- the bus master raises `rd_grant` only while `rd_req` is high;
- it delivers exactly five valid beats after the grant, with done on the fifth;
- the downstream engine keeps `dsc_ready` meaningful only while a descriptor is offered.

The bench drives every input on the falling edge and follows these rules for every well-formed fetch. The only exceptions are deliberate: stray valid/done beats are sent before the grant and while a descriptor is pending, and start is cleared or reset is raised in the middle of a fetch. All of these fall in the windows the requirements define as ignored or aborting.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned SIZE_W     = 19;
    localparam int unsigned REP_W      = 6;
    localparam int unsigned DESC_WORDS = 5;

    // Control word bit positions
    localparam int unsigned SIZE_LSB   = 13;
    localparam int unsigned REP_LSB    = 7;
    localparam int unsigned WFIX_BIT   = 6;
    localparam int unsigned RFIX_BIT   = 5;
    localparam int unsigned DIR_BIT    = 1;

    // Word slots inside a descriptor
    localparam int unsigned SLOT_CTRL  = 0;
    localparam int unsigned SLOT_LINK  = 1;
    localparam int unsigned SLOT_DST   = 2;
    localparam int unsigned SLOT_SRC   = 3;
    localparam int unsigned SLOT_SPARE = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQUEST,
        ST_RECEIVE,
        ST_PRESENT,
        ST_FINISHED
    } fetch_state_e;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic [REP_W-1:0]  repeat_n;
        logic              wr_fix;
        logic              rd_fix;
        logic              is_write;
        logic [ADDR_W-1:0] wr_addr;
        logic [ADDR_W-1:0] rd_addr;
        logic [ADDR_W-1:0] next_ptr;
        logic              last;
    } desc_t;
endpackage

// File: rtl/dcf_word_stage.sv
`timescale 1ns/1ps
module dcf_word_stage #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned BUS_W  = 128,
    parameter int unsigned NWORDS = 5
) (
    input  logic                           clk,
    input  logic                           clr,
    input  logic                           cap,
    input  logic [BUS_W-1:0]               bus_data,
    output logic [NWORDS-1:0][WORD_W-1:0]  words
);
    localparam int unsigned IDX_W = $clog2(NWORDS + 1);

    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] lane;
    logic              unused_low_lanes;

    assign lane             = bus_data[BUS_W-1 -: WORD_W];
    assign unused_low_lanes = ^bus_data[BUS_W-WORD_W-1:0];

    // Index advances only on a captured beat and saturates past the last slot
    always_ff @(posedge clk) begin
        if (clr) begin
            idx <= '0;
        end else if (cap && (idx < IDX_W'(NWORDS))) begin
            idx <= idx + 1'b1;
        end
    end

    for (genvar g = 0; g < NWORDS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (cap && (idx == IDX_W'(g))) begin
                words[g] <= lane;
            end
        end
    end
endmodule

// File: rtl/dcf_decode.sv
`timescale 1ns/1ps
module dcf_decode
    import dcf_pkg::*;
#(
    parameter int unsigned NWORDS = DESC_WORDS
) (
    input  logic [NWORDS-1:0][WORD_W-1:0] words,
    output desc_t                         desc
);
    logic [WORD_W-1:0] ctrl;
    logic [WORD_W-1:0] link;
    logic              unused_fields;

    assign ctrl = words[SLOT_CTRL];
    assign link = words[SLOT_LINK];

    always_comb begin
        desc.size     = ctrl[SIZE_LSB +: SIZE_W];
        desc.repeat_n = ctrl[REP_LSB +: REP_W];
        desc.wr_fix   = ctrl[WFIX_BIT];
        desc.rd_fix   = ctrl[RFIX_BIT];
        desc.is_write = ctrl[DIR_BIT];
        desc.wr_addr  = words[SLOT_DST];
        desc.rd_addr  = words[SLOT_SRC];
        desc.next_ptr = {link[ADDR_W-1:2], 2'b00};
        desc.last     = link[0];
    end

    // Reserved control bits, link bit 1 and the spare word carry no meaning
    assign unused_fields = ^{ctrl[4:2], ctrl[0], link[1], words[SLOT_SPARE]};
endmodule

// File: rtl/dcf_fsm.sv
`timescale 1ns/1ps
module dcf_fsm
    import dcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_en,
    input  logic [ADDR_W-1:0] first_ptr,
    input  logic              rd_grant,
    input  logic              rd_valid,
    input  logic              rd_done,
    input  logic              dsc_ready,
    input  logic              desc_last,
    input  logic [ADDR_W-1:0] desc_next,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              dsc_valid,
    output logic              stage_clr,
    output logic              stage_cap
);
    fetch_state_e      state, state_nx;
    logic [ADDR_W-1:0] ptr_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start_en) state_nx = ST_REQUEST;
            ST_REQUEST:  if (rd_grant) state_nx = ST_RECEIVE;
            ST_RECEIVE:  if (rd_valid && rd_done) state_nx = ST_PRESENT;
            ST_PRESENT:  if (dsc_ready) state_nx = desc_last ? ST_FINISHED : ST_REQUEST;
            ST_FINISHED: state_nx = ST_FINISHED;
            default:     state_nx = ST_IDLE;
        endcase
        if (!start_en) state_nx = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ptr_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start_en) begin
                ptr_q <= first_ptr;
            end else if (state == ST_PRESENT && dsc_ready && !desc_last && start_en) begin
                ptr_q <= desc_next;
            end
        end
    end

    always_comb begin
        rd_req    = 1'b0;
        dsc_valid = 1'b0;
        stage_clr = 1'b1;
        stage_cap = 1'b0;
        unique case (state)
            ST_IDLE:     ;
            ST_REQUEST:  rd_req = 1'b1;
            ST_RECEIVE: begin
                stage_clr = 1'b0;
                stage_cap = rd_valid;
            end
            ST_PRESENT:  dsc_valid = 1'b1;
            ST_FINISHED: ;
            default:     ;
        endcase
    end

    assign rd_addr = ptr_q;
endmodule

// File: rtl/desc_chain_fetcher.sv
`timescale 1ns/1ps
module desc_chain_fetcher
    import dcf_pkg::*;
#(
    parameter int unsigned BUS_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_en,
    input  logic [31:0]       first_ptr,
    output logic              rd_req,
    output logic [31:0]       rd_addr,
    input  logic              rd_grant,
    input  logic              rd_valid,
    input  logic              rd_done,
    input  logic [BUS_W-1:0]  rd_data,
    output logic              dsc_valid,
    input  logic              dsc_ready,
    output logic [18:0]       dsc_size,
    output logic [5:0]        dsc_repeat,
    output logic              dsc_wr_fix,
    output logic              dsc_rd_fix,
    output logic              dsc_is_write,
    output logic [31:0]       dsc_wr_addr,
    output logic [31:0]       dsc_rd_addr,
    output logic              dsc_last
);
    logic                               stage_clr;
    logic                               stage_cap;
    logic [DESC_WORDS-1:0][WORD_W-1:0]  words;
    desc_t                              desc;

    dcf_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_en  (start_en),
        .first_ptr (first_ptr),
        .rd_grant  (rd_grant),
        .rd_valid  (rd_valid),
        .rd_done   (rd_done),
        .dsc_ready (dsc_ready),
        .desc_last (desc.last),
        .desc_next (desc.next_ptr),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .dsc_valid (dsc_valid),
        .stage_clr (stage_clr),
        .stage_cap (stage_cap)
    );

    dcf_word_stage #(
        .WORD_W (WORD_W),
        .BUS_W  (BUS_W),
        .NWORDS (DESC_WORDS)
    ) u_stage (
        .clk      (clk),
        .clr      (stage_clr || rst),
        .cap      (stage_cap),
        .bus_data (rd_data),
        .words    (words)
    );

    dcf_decode #(
        .NWORDS (DESC_WORDS)
    ) u_dec (
        .words (words),
        .desc  (desc)
    );

    assign dsc_size     = desc.size;
    assign dsc_repeat   = desc.repeat_n;
    assign dsc_wr_fix   = desc.wr_fix;
    assign dsc_rd_fix   = desc.rd_fix;
    assign dsc_is_write = desc.is_write;
    assign dsc_wr_addr  = desc.wr_addr;
    assign dsc_rd_addr  = desc.rd_addr;
    assign dsc_last     = desc.last;
endmodule

// File: rtl/dcf_checker.sv
`timescale 1ns/1ps
module dcf_checker (
    input logic        clk,
    input logic        rst,
    input logic        start_en,
    input logic        rd_req,
    input logic        rd_grant,
    input logic [31:0] rd_addr,
    input logic        dsc_valid,
    input logic        dsc_ready,
    input logic        dsc_last,
    input logic [18:0] dsc_size,
    input logic [31:0] dsc_wr_addr,
    input logic [31:0] dsc_rd_addr
);
    // R8: one descriptor pending at most, so no fetch while offering
    p_no_fetch_pending_r8: assert property (@(posedge clk) disable iff (rst)
        dsc_valid |-> !rd_req);

    // R8: offered descriptor frozen under backpressure
    p_offer_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (dsc_valid && !dsc_ready && start_en) |=>
            (dsc_valid && $stable(dsc_size) && $stable(dsc_wr_addr) && $stable(dsc_rd_addr)));

    // R3: request persists until granted
    p_req_waits_grant_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_grant && start_en) |=> (rd_req && $stable(rd_addr)));

    // R3: grant ends the request
    p_grant_ends_req_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_grant) |=> !rd_req);

    // R11: clearing start aborts
    p_abort_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !start_en |=> (!rd_req && !dsc_valid));

    // R10: nothing fetched after the terminator is taken
    p_halt_after_last_r10: assert property (@(posedge clk) disable iff (rst)
        (dsc_valid && dsc_ready && dsc_last) |=> !rd_req);
endmodule

bind desc_chain_fetcher dcf_checker u_dcf_checker (
    .clk         (clk),
    .rst         (rst),
    .start_en    (start_en),
    .rd_req      (rd_req),
    .rd_grant    (rd_grant),
    .rd_addr     (rd_addr),
    .dsc_valid   (dsc_valid),
    .dsc_ready   (dsc_ready),
    .dsc_last    (dsc_last),
    .dsc_size    (dsc_size),
    .dsc_wr_addr (dsc_wr_addr),
    .dsc_rd_addr (dsc_rd_addr)
);

// File: tb/desc_chain_fetcher_bench.sv
`timescale 1ns/1ps
module desc_chain_fetcher_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_en = 1'b0;
    logic [31:0]  first_ptr = '0;
    logic         rd_req;
    logic [31:0]  rd_addr;
    logic         rd_grant = 1'b0;
    logic         rd_valid = 1'b0;
    logic         rd_done = 1'b0;
    logic [127:0] rd_data = '0;
    logic         dsc_valid;
    logic         dsc_ready = 1'b0;
    logic [18:0]  dsc_size;
    logic [5:0]   dsc_repeat;
    logic         dsc_wr_fix, dsc_rd_fix, dsc_is_write, dsc_last;
    logic [31:0]  dsc_wr_addr, dsc_rd_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    desc_chain_fetcher u_desc_chain_fetcher (
        .clk(clk), .rst(rst), .start_en(start_en), .first_ptr(first_ptr),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_grant(rd_grant),
        .rd_valid(rd_valid), .rd_done(rd_done), .rd_data(rd_data),
        .dsc_valid(dsc_valid), .dsc_ready(dsc_ready),
        .dsc_size(dsc_size), .dsc_repeat(dsc_repeat),
        .dsc_wr_fix(dsc_wr_fix), .dsc_rd_fix(dsc_rd_fix),
        .dsc_is_write(dsc_is_write), .dsc_wr_addr(dsc_wr_addr),
        .dsc_rd_addr(dsc_rd_addr), .dsc_last(dsc_last)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Control word per R5: size 31:13, repeat 12:7, wfix 6, rfix 5, write 1
    function automatic logic [31:0] mk_ctrl(input int size, input int rep,
                                            input bit wf, input bit rf, input bit wr);
        return {19'(size), 6'(rep), wf, rf, 3'b101, wr, 1'b1};
    endfunction

    task automatic beat(input logic [31:0] w, input bit last_beat);
        rd_valid = 1'b1;
        rd_done  = last_beat;
        rd_data  = {w, 96'h1234_5678_9abc_def0_0f0f_0f0f};
        @(negedge clk);
        rd_valid = 1'b0;
        rd_done  = 1'b0;
    endtask

    task automatic wait_req();
        while (!rd_req) @(negedge clk);
    endtask

    task automatic grant_now();
        rd_grant = 1'b1;
        @(negedge clk);
        rd_grant = 1'b0;
        chk("R3", "request dropped after grant", rd_req, 1'b0);
    endtask

    task automatic serve(input string req, input logic [31:0] exp_addr,
                         input logic [31:0] w0, input logic [31:0] w1,
                         input logic [31:0] w2, input logic [31:0] w3,
                         input logic [31:0] w4, input int gdly,
                         input bit gaps, input bit stray);
        logic [31:0] w [5];
        w = '{w0, w1, w2, w3, w4};
        wait_req();
        chk(req, "fetch address", rd_addr, exp_addr);
        for (int k = 0; k < gdly; k++) begin
            if (stray) begin
                rd_valid = 1'b1;
                rd_done  = 1'b1;
                rd_data  = {32'hBADC_0DE5, 96'h0};
            end
            @(negedge clk);
            rd_valid = 1'b0;
            rd_done  = 1'b0;
            chk("R3", "request held before grant", rd_req, 1'b1);
            chk("R3", "address held before grant", rd_addr, exp_addr);
        end
        grant_now();
        for (int i = 0; i < 5; i++) begin
            beat(w[i], i == 4);
            if (gaps && i < 4) @(negedge clk);
        end
    endtask

    task automatic check_desc(input logic [31:0] w0, input logic [31:0] w2,
                              input logic [31:0] w3, input bit last);
        chk("R4", "offered after done beat", dsc_valid, 1'b1);
        chk("R5", "size", dsc_size, w0[31:13]);
        chk("R5", "repeat", dsc_repeat, w0[12:7]);
        chk("R5", "dst fixed", dsc_wr_fix, w0[6]);
        chk("R5", "src fixed", dsc_rd_fix, w0[5]);
        chk("R5", "direction", dsc_is_write, w0[1]);
        chk("R6", "dst address", dsc_wr_addr, w2);
        chk("R6", "src address", dsc_rd_addr, w3);
        chk("R7", "terminator flag", dsc_last, last);
    endtask

    task automatic accept();
        dsc_ready = 1'b1;
        @(negedge clk);
        dsc_ready = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "req in reset", rd_req, 1'b0);
        chk("R1", "valid in reset", dsc_valid, 1'b0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "req idle, start low", rd_req, 1'b0);
        chk("R1", "valid idle, start low", dsc_valid, 1'b0);
    endtask

    task automatic t_chain();
        logic [31:0] a0, b0, c0;
        a0 = mk_ctrl(100, 3, 1'b1, 1'b0, 1'b1);
        b0 = mk_ctrl(19'h7FFFF, 63, 1'b0, 1'b1, 1'b0);
        c0 = mk_ctrl(4, 0, 1'b1, 1'b1, 1'b1);
        first_ptr = 32'h0000_1000;
        start_en  = 1'b1;
        // A: link 0x2000 with bit 1 set as noise, not last (R7)
        serve("R2", 32'h0000_1000, a0, 32'h0000_2002, 32'hA000_0010,
              32'hB000_0020, 32'hFFFF_FFFF, 2, 1'b0, 1'b1);
        check_desc(a0, 32'hA000_0010, 32'hB000_0020, 1'b0);
        // stray beat while offering must be ignored
        rd_valid = 1'b1; rd_done = 1'b1; rd_data = {32'h5555_5555, 96'h0};
        @(negedge clk);
        rd_valid = 1'b0; rd_done = 1'b0;
        chk("R4", "stray beat ignored while offering", dsc_wr_addr, 32'hA000_0010);
        chk("R8", "no fetch while pending", rd_req, 1'b0);
        accept();
        chk("R9", "next request raised", rd_req, 1'b1);
        chk("R7", "next address masked", rd_addr, 32'h0000_2000);
        // B: gaps between beats, then backpressure
        serve("R9", 32'h0000_2000, b0, 32'h0000_3000, 32'h1111_1110,
              32'h2222_2220, 32'h0, 0, 1'b1, 1'b0);
        check_desc(b0, 32'h1111_1110, 32'h2222_2220, 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8", "held under backpressure", dsc_valid, 1'b1);
            chk("R8", "no fetch under backpressure", rd_req, 1'b0);
            chk("R8", "fields stable", dsc_rd_addr, 32'h2222_2220);
        end
        accept();
        // C: terminator
        serve("R9", 32'h0000_3000, c0, 32'h0000_0001, 32'hC0C0_0000,
              32'hD0D0_0004, 32'h0, 0, 1'b0, 1'b0);
        check_desc(c0, 32'hC0C0_0000, 32'hD0D0_0004, 1'b1);
        accept();
        for (int k = 0; k < 4; k++) begin
            chk("R10", "no request after terminator", rd_req, 1'b0);
            chk("R10", "nothing offered after terminator", dsc_valid, 1'b0);
            @(negedge clk);
        end
        start_en = 1'b0;
        @(negedge clk);
        start_en = 1'b1;
        @(negedge clk);
        chk("R10", "restart request", rd_req, 1'b1);
        chk("R10", "restart from first pointer", rd_addr, 32'h0000_1000);
    endtask

    task automatic t_abort();
        logic [31:0] d0;
        d0 = mk_ctrl(7, 1, 1'b0, 1'b0, 1'b0);
        wait_req();
        grant_now();
        beat(32'hDEAD_0000, 1'b0);
        beat(32'hDEAD_0001, 1'b0);
        start_en = 1'b0;
        @(negedge clk);
        chk("R11", "request dropped on abort", rd_req, 1'b0);
        chk("R11", "nothing offered on abort", dsc_valid, 1'b0);
        @(negedge clk);
        first_ptr = 32'h0000_4000;
        start_en  = 1'b1;
        serve("R11", 32'h0000_4000, d0, 32'h0000_5001, 32'h0404_0400,
              32'h0808_0800, 32'h0, 0, 1'b0, 1'b0);
        check_desc(d0, 32'h0404_0400, 32'h0808_0800, 1'b1);
        chk("R11", "reload starts at word 0", dsc_size, 19'd7);
        accept();
        start_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_midreset();
        logic [31:0] e0;
        e0 = mk_ctrl(256, 9, 1'b1, 1'b0, 1'b0);
        first_ptr = 32'h0000_6000;
        start_en  = 1'b1;
        wait_req();
        grant_now();
        beat(32'hEEEE_0000, 1'b0);
        beat(32'hEEEE_0001, 1'b0);
        beat(32'hEEEE_0002, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        chk("R12", "request dropped by reset", rd_req, 1'b0);
        chk("R12", "nothing offered in reset", dsc_valid, 1'b0);
        start_en = 1'b0;
        rst      = 1'b0;
        @(negedge clk);
        chk("R12", "idle after reset", rd_req, 1'b0);
        start_en = 1'b1;
        serve("R12", 32'h0000_6000, e0, 32'h0000_7001, 32'h6060_6060,
              32'h7070_7070, 32'h0, 1, 1'b1, 1'b0);
        check_desc(e0, 32'h6060_6060, 32'h7070_7070, 1'b1);
        accept();
        start_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_chain();
        t_abort();
        t_midreset();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired, all requirements: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule